// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's complement operands, a multiplier X and a multiplicand Y. It uses one radix-4 Booth digit per clock. X is recoded from overlapping bit triplets into digits between -2 and +2. Each digit chooses zero, Y or twice Y, and an adder/subtractor folds that choice into a running partial product. The partial product moves two bit positions left before each new digit. The digits are consumed from the most significant end, so the shift and the sign extension both happen in one accumulator.

A caller drives `start_i` for one cycle with the operands on `x_i` and `y_i`. The block samples the operands on that edge. It works through ceil(XW/2) digits and then pulses `done_o` for one cycle. The product on `product_o` is valid from that pulse and holds until the next run completes. For an odd multiplier width, a zero is placed below the LSB so that every group is a full triplet, and the doubled result is halved on output.

Top module: `booth_mul_seq`

## Requirements
- R1: `product_o` equals the exact signed product X*Y on XW+YW bits, for every operand pair.
- R2: Each triplet (x[m+1], x[m], x[m-1]) is recoded as -2*x[m+1]+x[m]+x[m-1]. The mapping is 000 to 0, 001 and 010 to +1, 011 to +2, 100 to -2, 101 and 110 to -1, and 111 to 0. Triplets overlap by one bit, and the bit below the LSB reads as 0.
- R3: The most negative value times the most negative value gives +2^(XW+YW-2) with no overflow. With the 8-bit defaults this is 16384.
- R4: `done_o` goes high for exactly one cycle. It rises on the ND-th rising edge after the edge that samples `start_i`, where ND = ceil(XW/2). With the 8-bit defaults, ND = 4.
- R5: `product_o` changes only on the edge where `done_o` rises. It keeps its value while idle and throughout a following run until that run's `done_o`.
- R6: A `start_i` that arrives while a run is in progress is ignored. The running product and its latency are unaffected.
- R7: With an odd XW, such as XW = YW = 5, the multiplier is padded with a zero below the LSB and every product is still exact.
- R8: After reset, `done_o` is 0 and `product_o` is 0.
- R9: Changes on `x_i` and `y_i` after the start edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication; sampled while idle |
| x_i | input | XW | Signed multiplier, recoded into Booth digits |
| y_i | input | YW | Signed multiplicand |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | XW+YW | Signed product, held between runs |

## Verification
The hardest situations to reach are a start request that lands in the middle of a run and the bottom-padded grouping used for odd widths. The bench raises `start_i` with different operands two cycles into a run. It then checks that both the result and the done cycle match the first request. A second instance with 5-bit operands is swept over all 1024 pairs, which exercises the padding digit and the final halving. The most-negative-squared case is driven directly on both widths. Every X value is swept so that each triplet pattern occurs at each digit position.

// File: rtl/booth_pkg.sv
`timescale 1ns/1ps
package booth_pkg;

  typedef enum logic [1:0] {
    MAG_ZERO = 2'd0,
    MAG_ONE  = 2'd1,
    MAG_TWO  = 2'd2
  } booth_mag_e;

  typedef struct packed {
    logic       neg;
    booth_mag_e mag;
  } booth_digit_t;

  function automatic int digit_value(booth_digit_t d);
    int v;
    case (d.mag)
      MAG_ONE: v = 1;
      MAG_TWO: v = 2;
      default: v = 0;
    endcase
    return d.neg ? -v : v;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
`timescale 1ns/1ps
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0]   trip_i,   // {x[m+1], x[m], x[m-1]}
  output booth_digit_t digit_o
);

  logic all_same;
  logic is_two;

  assign all_same = (trip_i == 3'b000) || (trip_i == 3'b111);
  assign is_two   = (trip_i == 3'b011) || (trip_i == 3'b100);

  always_comb begin
    digit_o.neg = trip_i[2] & ~all_same;
    if (all_same)    digit_o.mag = MAG_ZERO;
    else if (is_two) digit_o.mag = MAG_TWO;
    else             digit_o.mag = MAG_ONE;
  end

endmodule

// File: rtl/booth_slice.sv
`timescale 1ns/1ps
module booth_slice
  import booth_pkg::*;
#(
  parameter int YW = 8,
  parameter int AW = 18
) (
  input  logic [AW-1:0] acc_i,
  input  logic [YW-1:0] y_i,
  input  booth_digit_t  digit_i,
  output logic [AW-1:0] acc_o
);

  logic [AW-1:0] y_ext;
  logic [AW-1:0] pick;
  logic [AW-1:0] addend;
  logic [AW-1:0] shifted;

  assign y_ext = {{(AW-YW){y_i[YW-1]}}, y_i};

  always_comb begin
    case (digit_i.mag)
      MAG_ONE: pick = y_ext;
      MAG_TWO: pick = {y_ext[AW-2:0], 1'b0};
      default: pick = '0;
    endcase
  end

  // subtract as invert plus carry-in
  assign addend  = digit_i.neg ? ~pick : pick;
  assign shifted = {acc_i[AW-3:0], 2'b00};
  assign acc_o   = shifted + addend + {{(AW-1){1'b0}}, digit_i.neg};

endmodule

// File: rtl/booth_ctrl.sv
`timescale 1ns/1ps
module booth_ctrl #(
  parameter int ND = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic done_o
);

  localparam int CW = (ND > 1) ? $clog2(ND) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign load_o   = start_i & ~busy_q;
  assign step_o   = busy_q;
  assign finish_o = busy_q && (cnt_q == CW'(ND - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (finish_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(cnt_q) < ND));

  assert_load_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (busy_q && cnt_q == '0));

  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !finish_o && start_i) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/booth_mul_seq.sv
`timescale 1ns/1ps
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [XW-1:0]    x_i,
  input  logic [YW-1:0]    y_i,
  output logic             done_o,
  output logic [XW+YW-1:0] product_o
);

  localparam int SH = XW % 2;       // bottom pad bits for odd widths
  localparam int XE = XW + SH;      // recoded width, always even
  localparam int ND = XE / 2;       // Booth digits
  localparam int PW = XW + YW;
  localparam int AW = XE + YW + 2;

  logic [XE-1:0] x_ext;
  logic [XE:0]   xq_q;              // multiplier with implicit zero below
  logic [YW-1:0] y_q;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_next;
  logic [PW-1:0] product_q;
  logic [2:0]    trip;
  booth_digit_t  digit;
  logic          load, step, finish;

  generate
    if (SH != 0) begin : g_odd
      assign x_ext = {x_i, {SH{1'b0}}};
    end else begin : g_even
      assign x_ext = x_i;
    end
  endgenerate

  booth_ctrl #(.ND(ND)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .done_o   (done_o)
  );

  assign trip = xq_q[XE -: 3];

  booth_recoder u_rec (
    .trip_i  (trip),
    .digit_o (digit)
  );

  booth_slice #(.YW(YW), .AW(AW)) u_slice (
    .acc_i   (acc_q),
    .y_i     (y_q),
    .digit_i (digit),
    .acc_o   (acc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xq_q      <= '0;
      y_q       <= '0;
      acc_q     <= '0;
      product_q <= '0;
    end else begin
      if (load) begin
        xq_q  <= {x_ext, 1'b0};
        y_q   <= y_i;
        acc_q <= '0;
      end else if (step) begin
        xq_q  <= {xq_q[XE-2:0], 2'b00};
        acc_q <= acc_next;
      end
      if (finish) product_q <= acc_next[SH +: PW];
    end
  end

  assign product_o = product_q;

  assert_digit_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> (digit_value(digit) == int'(trip[1]) + int'(trip[0]) - 2 * int'(trip[2])));

  assert_product_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(product_o) |-> done_o);

  assert_operand_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load) |=> $stable(y_q));

  assert_odd_pad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load) |-> (xq_q[0] == 1'b0));

endmodule

// File: tb/tb_booth_mul_seq.sv
`timescale 1ns/1ps
module tb_booth_mul_seq;

  localparam int ND8 = 4;
  localparam int ND5 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              start8 = 1'b0, start5 = 1'b0;
  logic signed [7:0] x8 = '0, y8 = '0;
  logic signed [4:0] x5 = '0, y5 = '0;
  logic              done8, done5;
  logic [15:0]       prod8;
  logic [9:0]        prod5;

  int checks = 0;
  int fails  = 0;

  booth_mul_seq #(.XW(8), .YW(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start8),
    .x_i(x8), .y_i(y8), .done_o(done8), .product_o(prod8));

  booth_mul_seq #(.XW(5), .YW(5)) dut_odd (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start5),
    .x_i(x5), .y_i(y5), .done_o(done5), .product_o(prod5));

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one 8-bit op; scramble inputs after start (R9), check done timing (R4)
  task automatic op8(input logic signed [7:0] a, input logic signed [7:0] b, input string req);
    logic signed [15:0] exp;
    bit bad;
    exp = 16'(a * b);
    bad = 0;
    @(negedge clk); x8 = a; y8 = b; start8 = 1'b1;
    @(negedge clk); start8 = 1'b0; x8 = ~a; y8 = ~b;
    for (int i = 1; i <= ND8; i++) begin
      @(negedge clk);
      if (done8 !== (i == ND8)) bad = 1;
    end
    check(!bad && prod8 === exp, req, int'($signed(prod8)), int'(exp));
    @(negedge clk);
    check(done8 === 1'b0 && prod8 === exp, "R4 pulse/R5 hold", int'(done8), 0);
  endtask

  task automatic op5(input logic signed [4:0] a, input logic signed [4:0] b, input string req);
    logic signed [9:0] exp;
    bit bad;
    exp = 10'(a * b);
    bad = 0;
    @(negedge clk); x5 = a; y5 = b; start5 = 1'b1;
    @(negedge clk); start5 = 1'b0; x5 = ~a; y5 = ~b;
    for (int i = 1; i <= ND5; i++) begin
      @(negedge clk);
      if (done5 !== (i == ND5)) bad = 1;
    end
    check(!bad && prod5 === exp, req, int'($signed(prod5)), int'(exp));
  endtask

  task automatic t_reset;  // R8
    check(done8 === 1'b0 && prod8 === 16'd0, "R8 reset 8b", int'(prod8), 0);
    check(done5 === 1'b0 && prod5 === 10'd0, "R8 reset 5b", int'(prod5), 0);
  endtask

  task automatic t_corners;  // R3 and R1 extremes
    op8(-8'sd128, -8'sd128, "R3 min*min");
    check(prod8 === 16'd16384, "R3 value", int'(prod8), 16384);
    op8(8'sd127, -8'sd128, "R1 max*min");
    op8(8'sd127, 8'sd127, "R1 max*max");
    op8(8'sd0, -8'sd77, "R1 zero");
    op8(-8'sd1, -8'sd1, "R1 neg one");
    op5(-5'sd16, -5'sd16, "R3 R7 min*min odd");
    check(prod5 === 10'd256, "R3 odd value", int'(prod5), 256);
  endtask

  task automatic t_busy_start;  // R6
    @(negedge clk); x8 = 8'sd57; y8 = -8'sd93; start8 = 1'b1;
    @(negedge clk); start8 = 1'b0;
    @(negedge clk); x8 = -8'sd3; y8 = 8'sd11; start8 = 1'b1;
    @(negedge clk); start8 = 1'b0;
    @(negedge clk);
    check(done8 === 1'b0, "R6 no early done", int'(done8), 0);
    @(negedge clk);
    check(done8 === 1'b1 && $signed(prod8) === 16'(57 * -93), "R6 busy start ignored",
          int'($signed(prod8)), 57 * -93);
    @(negedge clk);
    check(done8 === 1'b0, "R6 single done", int'(done8), 0);
  endtask

  task automatic t_hold;  // R5
    logic [15:0] held;
    op8(8'sd45, 8'sd3, "R5 setup");
    held = prod8;
    repeat (6) @(negedge clk);
    check(prod8 === held, "R5 idle hold", int'(prod8), int'(held));
    @(negedge clk); x8 = -8'sd9; y8 = 8'sd10; start8 = 1'b1;
    @(negedge clk); start8 = 1'b0;
    repeat (ND8 - 1) @(negedge clk);
    check(prod8 === held, "R5 hold during run", int'(prod8), int'(held));
    @(negedge clk);
    check(done8 === 1'b1 && $signed(prod8) === -16'sd90, "R5 update at done",
          int'($signed(prod8)), -90);
  endtask

  task automatic t_sweep8;  // R1, R2 (every triplet at every digit via full X range), R9
    for (int a = -128; a < 128; a++)
      for (int b = -128; b < 128; b += 4)
        op8(8'(a), 8'(b), "R1 R2 sweep");
  endtask

  task automatic t_sweep5;  // R7 odd width exhaustive
    for (int a = -16; a < 16; a++)
      for (int b = -16; b < 16; b++)
        op5(5'(a), 5'(b), "R7 odd sweep");
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_corners();
    t_busy_start();
    t_hold();
    t_sweep5();
    t_sweep8();
    report();
  end

endmodule